// File: doc/BRIEF.md
# IDE Bus-Master DMA Register Bank

This block holds the host-visible registers of a two-channel IDE bus-master DMA controller and combines the channels' interrupt requests. A host reaches it over a simple byte-addressed register port, which carries an address, an access size in bytes, read and write strobes, and write and read data. Each channel has an 8-byte slot. The slot holds a command byte, which carries the start and direction bits, and a status byte. The status byte has a read-only active flag, two flags that a write of one clears, and two bits the host writes freely. The slot also holds a descriptor-table address of up to four bytes. The DMA engine reads the start bit, the direction bit and the descriptor address, and it raises the error and interrupt flags through set pulses.

Each channel's drive side gives a level interrupt. The block copies that level into a per-channel pending bit one clock later and ORs the pending bits together. It drives the result on a single legacy interrupt pin, but only while a 4-bit interrupt-line field is nonzero. After the channel slots come two more byte registers: the line field, then a read-only copy of the pending bits. The bank honours only single-byte accesses. A wider read returns all ones across the requested width, and a wider write does nothing.

Top module: `idebm_regbank`

## Requirements
- R1: Only accesses with size 1 take effect. A read of size 2 returns 0x0000FFFF and a read of size 4 returns 0xFFFFFFFF. A write of any size other than 1 changes no register.
- R2: Within a channel slot, offsets 1 and 3 read 0xFF, and writes to them change nothing.
- R3: A byte write to status (slot offset 2) sets bits 5 and 6 to the written bits and keeps bit 0. Bits 1 and 2 are cleared where the written bit is 1 and kept where it is 0. Bits 3, 4 and 7 read 0.
- R4: An error-set pulse for a channel sets its status bit 1, and an interrupt-set pulse sets its status bit 2. Each takes effect on the next clock.
- R5: The command byte (slot offset 0) stores only bit 0 (start) and bit 3 (direction), and the other bits read 0. The start and direction bits appear on dma_start and dma_dir one clock after the write.
- R6: The host cannot write status bit 0. A command write copies the written start bit into status bit 0.
- R7: Descriptor address bytes sit at slot offsets 4 to 7, least significant first, and each takes a byte write. The low 2 bits of the address always read 0. The address appears on dma_desc.
- R8: Channel n's slot starts at byte address 8·n. A write into one channel's slot leaves the other channel unchanged.
- R9: Each channel's interrupt level is copied into a pending bit one clock later. Address 8·NUM_CH+1 reads the pending bits, with channel n at bit n.
- R10: irq_out is high exactly when some pending bit is set and the line field is nonzero.
- R11: The line field at address 8·NUM_CH keeps only the low 4 bits of a write, and its upper bits read 0. It resets to 0x0E.
- R12: After a synchronous reset, command, status, descriptor addresses and pending bits are all zero, and irq_out is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_addr | input | AW | Byte address of the access |
| host_size | input | 3 | Access size in bytes |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | DW | Write data; a byte access uses bits 7:0 |
| host_rdata | output | DW | Read data, valid in the cycle host_rd is high |
| chan_irq | input | NUM_CH | Per-channel drive interrupt level |
| dma_err_set | input | NUM_CH | Pulse that sets a channel's error flag |
| dma_int_set | input | NUM_CH | Pulse that sets a channel's interrupt flag |
| dma_start | output | NUM_CH | Per-channel start bit |
| dma_dir | output | NUM_CH | Per-channel direction bit |
| dma_desc | output | NUM_CH·8·DESC_BYTES | Descriptor addresses, channel 0 in the low bits |
| irq_out | output | 1 | Combined, line-gated interrupt |

## Verification
The bench builds the block with its defaults: two channels, four-byte descriptor addresses, a 5-bit address and 32-bit data. With these values it can reach both channel slots, the line and pending bytes at 0x10 and 0x11, and every descriptor byte, including the byte whose low bits are forced to zero. The 32-bit data width lets the bench see both the half-width and the full-width all-ones read responses. Two channels make it possible to check that each pending bit alone raises the pin and that a write into one slot leaves the other slot alone.

// File: rtl/idebm_pkg.sv
package idebm_pkg;
   localparam int SLOT_BYTES = 8;
   localparam int OFS_CMD    = 0;
   localparam int OFS_STS    = 2;
   localparam int OFS_DESC   = 4;
   localparam int CMD_GO     = 0;
   localparam int CMD_TOMEM  = 3;
   localparam int STS_ACT    = 0;
   localparam int STS_ERR    = 1;
   localparam int STS_INT    = 2;
   localparam logic [7:0] STS_KEEP = 8'h01;
   localparam logic [7:0] STS_W1C  = 8'h06;
   localparam logic [7:0] STS_FREE = 8'h60;

   // Host write into the status byte: free bits load, active holds, flags clear on one.
   function automatic logic [7:0] sts_merge(input logic [7:0] cur, input logic [7:0] wd);
      return (wd & STS_FREE) | (cur & STS_KEEP) | (cur & ~wd & STS_W1C);
   endfunction
endpackage

// File: rtl/idebm_chan.sv
module idebm_chan
   import idebm_pkg::*;
#(
   parameter int DESC_BYTES = 4
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    we,
   input  logic [2:0]              ofs,
   input  logic [7:0]              wd,
   input  logic                    err_set,
   input  logic                    int_set,
   output logic [7:0]              rbyte,
   output logic                    go_o,
   output logic                    dir_o,
   output logic [8*DESC_BYTES-1:0] desc_o
);
   logic       go_q, dir_q;
   logic [7:0] sts_q, sts_d;
   logic [7:0] desc_q [DESC_BYTES];

   wire cmd_we = we && (ofs == 3'(OFS_CMD));
   wire sts_we = we && (ofs == 3'(OFS_STS));

   // Set pulses win over a clearing host write in the same cycle.
   always_comb begin
      sts_d = sts_q;
      if (sts_we) sts_d = sts_merge(sts_q, wd);
      if (cmd_we) sts_d[STS_ACT] = wd[CMD_GO];
      if (err_set) sts_d[STS_ERR] = 1'b1;
      if (int_set) sts_d[STS_INT] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         go_q  <= 1'b0;
         dir_q <= 1'b0;
         sts_q <= '0;
      end else begin
         sts_q <= sts_d;
         if (cmd_we) begin
            go_q  <= wd[CMD_GO];
            dir_q <= wd[CMD_TOMEM];
         end
      end
   end

   for (genvar k = 0; k < DESC_BYTES; k++) begin : g_desc
      localparam logic [7:0] KEEP = (k == 0) ? 8'hFC : 8'hFF;
      always_ff @(posedge clk) begin
         if (rst) desc_q[k] <= '0;
         else if (we && (ofs == 3'(OFS_DESC + k))) desc_q[k] <= wd & KEEP;
      end
      assign desc_o[k*8 +: 8] = desc_q[k];
   end

   always_comb begin
      rbyte = 8'hFF;
      if (ofs == 3'(OFS_CMD)) begin
         rbyte = '0;
         rbyte[CMD_GO]    = go_q;
         rbyte[CMD_TOMEM] = dir_q;
      end else if (ofs == 3'(OFS_STS)) begin
         rbyte = sts_q;
      end
      for (int k = 0; k < DESC_BYTES; k++)
         if (ofs == 3'(OFS_DESC + k)) rbyte = desc_q[k];
   end

   assign go_o  = go_q;
   assign dir_o = dir_q;
endmodule

// File: rtl/idebm_irq.sv
module idebm_irq #(
   parameter int                NUM_CH         = 2,
   parameter int                LINE_W         = 4,
   parameter logic [LINE_W-1:0] LINE_RST       = 'hE,
   parameter bit                GATE_ZERO_LINE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NUM_CH-1:0] lvl_i,
   input  logic              line_we,
   input  logic [LINE_W-1:0] line_wd,
   output logic [NUM_CH-1:0] mirror_o,
   output logic [LINE_W-1:0] line_o,
   output logic              irq_o
);
   logic [NUM_CH-1:0] mirror_q;
   logic [LINE_W-1:0] line_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         mirror_q <= '0;
         line_q   <= LINE_RST;
      end else begin
         mirror_q <= lvl_i;
         if (line_we) line_q <= line_wd;
      end
   end

   if (GATE_ZERO_LINE) begin : g_gated
      assign irq_o = (|mirror_q) && (line_q != '0);
   end else begin : g_open
      assign irq_o = |mirror_q;
   end

   assign mirror_o = mirror_q;
   assign line_o   = line_q;
endmodule

// File: rtl/idebm_regbank.sv
module idebm_regbank
   import idebm_pkg::*;
#(
   parameter int NUM_CH     = 2,
   parameter int AW         = 5,
   parameter int DW         = 32,
   parameter int DESC_BYTES = 4,
   parameter int LINE_W     = 4
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic [AW-1:0]                  host_addr,
   input  logic [2:0]                     host_size,
   input  logic                           host_wr,
   input  logic                           host_rd,
   input  logic [DW-1:0]                  host_wdata,
   output logic [DW-1:0]                  host_rdata,
   input  logic [NUM_CH-1:0]              chan_irq,
   input  logic [NUM_CH-1:0]              dma_err_set,
   input  logic [NUM_CH-1:0]              dma_int_set,
   output logic [NUM_CH-1:0]              dma_start,
   output logic [NUM_CH-1:0]              dma_dir,
   output logic [NUM_CH*8*DESC_BYTES-1:0] dma_desc,
   output logic                           irq_out
);
   localparam int SW        = AW - 3;
   localparam int DESC_W    = 8 * DESC_BYTES;
   localparam int LINE_ADDR = NUM_CH * SLOT_BYTES;
   localparam int MIR_ADDR  = LINE_ADDR + 1;

   initial begin
      if (NUM_CH < 1 || NUM_CH > 8) $error("NUM_CH must be 1..8");
      if (DESC_BYTES < 1 || DESC_BYTES > 4) $error("DESC_BYTES must be 1..4");
      if (LINE_W < 1 || LINE_W > 8) $error("LINE_W must be 1..8");
      if (DW < 8) $error("DW must be at least 8");
      if (AW < 4 || (1 << AW) <= MIR_ADDR) $error("AW too small for the map");
   end

   wire          byte_acc = (host_size == 3'd1);
   wire          byte_wr  = byte_acc && host_wr;
   wire [SW-1:0] slot     = host_addr[AW-1:3];
   wire [2:0]    ofs      = host_addr[2:0];

   logic [7:0]        chan_rb [NUM_CH];
   logic [NUM_CH-1:0] mirror;
   logic [LINE_W-1:0] line_val;

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      idebm_chan #(.DESC_BYTES(DESC_BYTES)) u_chan (
         .clk     (clk),
         .rst     (rst),
         .we      (byte_wr && (slot == SW'(n))),
         .ofs     (ofs),
         .wd      (host_wdata[7:0]),
         .err_set (dma_err_set[n]),
         .int_set (dma_int_set[n]),
         .rbyte   (chan_rb[n]),
         .go_o    (dma_start[n]),
         .dir_o   (dma_dir[n]),
         .desc_o  (dma_desc[n*DESC_W +: DESC_W])
      );
   end

   idebm_irq #(.NUM_CH(NUM_CH), .LINE_W(LINE_W)) u_irq (
      .clk      (clk),
      .rst      (rst),
      .lvl_i    (chan_irq),
      .line_we  (byte_wr && (host_addr == AW'(LINE_ADDR))),
      .line_wd  (host_wdata[LINE_W-1:0]),
      .mirror_o (mirror),
      .line_o   (line_val),
      .irq_o    (irq_out)
   );

   logic [7:0] sel;
   always_comb begin
      sel = 8'hFF;
      for (int n = 0; n < NUM_CH; n++)
         if (slot == SW'(n)) sel = chan_rb[n];
      if (host_addr == AW'(LINE_ADDR)) sel = 8'(line_val);
      if (host_addr == AW'(MIR_ADDR))  sel = 8'(mirror);
      host_rdata = '0;
      if (host_rd) begin
         if (byte_acc) host_rdata[7:0] = sel;
         else for (int i = 0; i < DW; i++) host_rdata[i] = (i < 8 * int'(host_size));
      end
   end
endmodule

// File: rtl/idebm_regbank_chk.sv
module idebm_regbank_chk #(
   parameter int NUM_CH     = 2,
   parameter int AW         = 5,
   parameter int DW         = 32,
   parameter int DESC_BYTES = 4,
   parameter int LINE_W     = 4
) (
   input logic                           clk,
   input logic                           rst,
   input logic [AW-1:0]                  host_addr,
   input logic [2:0]                     host_size,
   input logic                           host_wr,
   input logic                           host_rd,
   input logic [DW-1:0]                  host_wdata,
   input logic [DW-1:0]                  host_rdata,
   input logic [NUM_CH-1:0]              chan_irq,
   input logic [NUM_CH-1:0]              dma_start,
   input logic [NUM_CH-1:0]              dma_dir,
   input logic [NUM_CH*8*DESC_BYTES-1:0] dma_desc,
   input logic                           irq_out,
   input logic [LINE_W-1:0]              line_val
);
   localparam int LINE_ADDR = NUM_CH * 8;

   p_wide_rd_r1: assert property (@(posedge clk) disable iff (rst)
      host_rd && host_size == 3'd4 |-> host_rdata == {DW{1'b1}});

   p_wide_wr_r1: assert property (@(posedge clk) disable iff (rst)
      host_wr && host_size != 3'd1 |=> $stable(dma_start) && $stable(dma_dir) && $stable(dma_desc));

   p_pad_rd_r2: assert property (@(posedge clk) disable iff (rst)
      host_rd && host_size == 3'd1 && host_addr < AW'(LINE_ADDR) && host_addr[0] && !host_addr[2]
      |-> host_rdata == DW'(8'hFF));

   p_cmd_out_r5: assert property (@(posedge clk) disable iff (rst)
      host_wr && host_size == 3'd1 && host_addr == '0
      |=> dma_start[0] == $past(host_wdata[0]) && dma_dir[0] == $past(host_wdata[3]));

   p_desc_align_r7: assert property (@(posedge clk) disable iff (rst)
      dma_desc[1:0] == 2'b00);

   p_pend_quiet_r9: assert property (@(posedge clk) disable iff (rst)
      $past(chan_irq) == '0 |-> !irq_out);

   p_line_gate_r10: assert property (@(posedge clk) disable iff (rst)
      line_val == '0 |-> !irq_out);

   p_line_wr_r11: assert property (@(posedge clk) disable iff (rst)
      host_wr && host_size == 3'd1 && host_addr == AW'(LINE_ADDR)
      |=> line_val == $past(host_wdata[LINE_W-1:0]));
endmodule

bind idebm_regbank idebm_regbank_chk #(
   .NUM_CH(NUM_CH), .AW(AW), .DW(DW), .DESC_BYTES(DESC_BYTES), .LINE_W(LINE_W)
) u_chk (
   .clk(clk), .rst(rst), .host_addr(host_addr), .host_size(host_size),
   .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
   .host_rdata(host_rdata), .chan_irq(chan_irq), .dma_start(dma_start),
   .dma_dir(dma_dir), .dma_desc(dma_desc), .irq_out(irq_out), .line_val(line_val)
);

// File: tb/idebm_regbank_tb.sv
`timescale 1ns/1ps
module idebm_regbank_tb;
   localparam int NUM_CH = 2;
   localparam int AW = 5;
   localparam int DW = 32;
   localparam int DB = 4;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [AW-1:0] host_addr = '0;
   logic [2:0] host_size = 3'd1;
   logic host_wr = 1'b0, host_rd = 1'b0;
   logic [DW-1:0] host_wdata = '0;
   logic [DW-1:0] host_rdata;
   logic [NUM_CH-1:0] chan_irq = '0, dma_err_set = '0, dma_int_set = '0;
   logic [NUM_CH-1:0] dma_start, dma_dir;
   logic [NUM_CH*8*DB-1:0] dma_desc;
   logic irq_out;

   always #2 clk = ~clk;

   idebm_regbank u_dut (
      .clk(clk), .rst(rst), .host_addr(host_addr), .host_size(host_size),
      .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .chan_irq(chan_irq), .dma_err_set(dma_err_set),
      .dma_int_set(dma_int_set), .dma_start(dma_start), .dma_dir(dma_dir),
      .dma_desc(dma_desc), .irq_out(irq_out)
   );

   int n_vec = 0, n_bad = 0;
   bit done = 1'b0;
   logic [31:0] q_exp [$];
   string       q_tag [$];

   logic [7:0] m_sts [NUM_CH];
   logic       m_go  [NUM_CH];
   logic       m_dir [NUM_CH];

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // Monitor: compares each read strobe against the next expected item.
   always @(negedge clk) begin
      if (host_rd) begin
         if (q_exp.size() == 0) begin
            n_vec++; n_bad++;
            $display("FAIL scoreboard: unexpected read got %h expected none", host_rdata);
         end else begin
            chk(host_rdata, q_exp.pop_front(), q_tag.pop_front());
         end
      end
   end

   task automatic rd(input logic [AW-1:0] a, input logic [2:0] sz, input logic [31:0] exp, input string tag);
      @(posedge clk); #1;
      host_addr = a; host_size = sz; host_rd = 1'b1;
      q_exp.push_back(exp); q_tag.push_back(tag);
      @(posedge clk); #1;
      host_rd = 1'b0;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [2:0] sz, input logic [31:0] d);
      @(posedge clk); #1;
      host_addr = a; host_size = sz; host_wdata = d; host_wr = 1'b1;
      @(posedge clk); #1;
      host_wr = 1'b0;
   endtask

   task automatic wr_cmd(input int ch, input logic [7:0] v);
      wr(AW'(ch * 8), 3'd1, 32'(v));
      m_go[ch] = v[0]; m_dir[ch] = v[3]; m_sts[ch][0] = v[0];
   endtask

   task automatic wr_sts(input int ch, input logic [7:0] v);
      wr(AW'(ch * 8 + 2), 3'd1, 32'(v));
      m_sts[ch] = (v & 8'h60) | (m_sts[ch] & 8'h01) | (m_sts[ch] & ~v & 8'h06);
   endtask

   task automatic pulse(input int ch, input bit e, input bit i);
      @(posedge clk); #1;
      dma_err_set[ch] = e; dma_int_set[ch] = i;
      @(posedge clk); #1;
      dma_err_set = '0; dma_int_set = '0;
      if (e) m_sts[ch][1] = 1'b1;
      if (i) m_sts[ch][2] = 1'b1;
   endtask

   function automatic logic [31:0] exp_cmd(input int ch);
      return {28'd0, m_dir[ch], 2'b00, m_go[ch]};
   endfunction

   task automatic set_irq(input logic [NUM_CH-1:0] v);
      @(posedge clk); #1; chan_irq = v;
      @(posedge clk); #1;
   endtask

   initial begin
      for (int c = 0; c < NUM_CH; c++) begin m_sts[c] = '0; m_go[c] = 0; m_dir[c] = 0; end
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;

      // R12: reset state
      chk(32'(irq_out), 0, "R12 irq_out after reset");
      chk(32'(dma_start), 0, "R12 dma_start after reset");
      chk(dma_desc[31:0], 0, "R12 desc after reset");
      rd(5'h00, 3'd1, 32'h00, "R12 cmd0 reset");
      rd(5'h02, 3'd1, 32'h00, "R12 sts0 reset");
      rd(5'h0A, 3'd1, 32'h00, "R12 sts1 reset");
      rd(5'h11, 3'd1, 32'h00, "R12 pending reset");
      rd(5'h10, 3'd1, 32'h0E, "R11 line reset 0x0E");

      // R5, R6: command bits and active flag
      wr_cmd(0, 8'hFF);
      chk(32'(dma_start[0]), 1, "R5 start out");
      chk(32'(dma_dir[0]), 1, "R5 dir out");
      rd(5'h00, 3'd1, exp_cmd(0), "R5 cmd keeps bits 0,3");
      rd(5'h02, 3'd1, 32'(m_sts[0]), "R6 active follows start");
      wr_sts(0, 8'h00);
      rd(5'h02, 3'd1, 32'(m_sts[0]), "R6 host cannot clear active");
      wr_cmd(0, 8'h08);
      rd(5'h02, 3'd1, 32'(m_sts[0]), "R6 active cleared by start=0");
      chk(32'(dma_dir[0]), 1, "R5 dir stays set");

      // R4: set pulses
      pulse(0, 1, 0);
      rd(5'h02, 3'd1, 32'(m_sts[0]), "R4 error flag set");
      pulse(0, 0, 1);
      rd(5'h02, 3'd1, 32'(m_sts[0]), "R4 interrupt flag set");

      // R3: random status writes
      for (int it = 0; it < 24; it++) begin
         int ch;
         logic [7:0] v;
         ch = int'($urandom_range(0, 1));
         if ($urandom_range(0, 2) == 0) wr_cmd(ch, 8'($urandom));
         pulse(ch, 1'($urandom), 1'($urandom));
         v = 8'($urandom);
         wr_sts(ch, v);
         rd(AW'(ch * 8 + 2), 3'd1, 32'(m_sts[ch]), "R3 status masking");
      end

      // R2: pad offsets
      rd(5'h01, 3'd1, 32'hFF, "R2 offset 1 ch0");
      rd(5'h0B, 3'd1, 32'hFF, "R2 offset 3 ch1");
      wr(5'h01, 3'd1, 32'h5A);
      wr(5'h03, 3'd1, 32'hA5);
      rd(5'h00, 3'd1, exp_cmd(0), "R2 pad write leaves cmd");
      rd(5'h02, 3'd1, 32'(m_sts[0]), "R2 pad write leaves status");
      rd(5'h03, 3'd1, 32'hFF, "R2 offset 3 after write");

      // R1: non-byte accesses
      wr(5'h00, 3'd4, ~exp_cmd(0));
      rd(5'h00, 3'd1, exp_cmd(0), "R1 wide write ignored");
      wr(5'h10, 3'd2, 32'h0);
      rd(5'h10, 3'd1, 32'h0E, "R1 wide line write ignored");
      rd(5'h00, 3'd2, 32'h0000FFFF, "R1 size 2 read");
      rd(5'h02, 3'd4, 32'hFFFFFFFF, "R1 size 4 read");

      // R7: descriptor address
      wr(5'h0C, 3'd1, 32'hFF);
      wr(5'h0D, 3'd1, 32'h12);
      wr(5'h0E, 3'd1, 32'h34);
      wr(5'h0F, 3'd1, 32'h56);
      rd(5'h0C, 3'd1, 32'hFC, "R7 low bits forced zero");
      rd(5'h0F, 3'd1, 32'h56, "R7 top byte");
      chk(dma_desc[63:32], 32'h563412FC, "R7 dma_desc ch1");
      chk(dma_desc[31:0], 32'h0, "R8 ch0 desc untouched");

      // R8: slot stride
      wr_cmd(0, 8'h00);
      wr_cmd(1, 8'h01);
      chk(32'(dma_start), 32'h2, "R8 ch1 start only");
      rd(5'h00, 3'd1, exp_cmd(0), "R8 ch0 cmd unchanged");
      rd(5'h08, 3'd1, exp_cmd(1), "R8 ch1 cmd");

      // R9, R10, R11: interrupt path
      set_irq(2'b01);
      chk(32'(irq_out), 1, "R10 ch0 pending raises irq");
      rd(5'h11, 3'd1, 32'h01, "R9 pending bit 0");
      set_irq(2'b10);
      chk(32'(irq_out), 1, "R10 ch1 pending raises irq");
      rd(5'h11, 3'd1, 32'h02, "R9 pending bit 1");
      wr(5'h10, 3'd1, 32'hF0);
      rd(5'h10, 3'd1, 32'h00, "R11 line upper bits dropped");
      chk(32'(irq_out), 0, "R10 zero line suppresses irq");
      set_irq(2'b11);
      chk(32'(irq_out), 0, "R10 stays low with zero line");
      wr(5'h10, 3'd1, 32'hF3);
      rd(5'h10, 3'd1, 32'h03, "R11 line low nibble");
      chk(32'(irq_out), 1, "R10 nonzero line passes irq");
      set_irq(2'b00);
      chk(32'(irq_out), 0, "R9 pending cleared when level drops");

      repeat (3) @(posedge clk);
      if (q_exp.size() != 0) begin
         n_vec++; n_bad++;
         $display("FAIL scoreboard: %0d reads unanswered expected 0", q_exp.size());
      end
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_vec++; n_bad++;
         $display("FAIL watchdog: run hung got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule